// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Prioritised Alternate Functions

This block is an 8-bit general-purpose I/O port behind a small register bus. Each pin normally belongs to a GPIO data bit, and a per-bit direction bit decides whether that pin is driven. The two lowest pins are also shared with a serial link and with two PWM channels. For every pin, the block picks one owner by fixed priority and produces that pin's output value and output enable.

Pin inputs pass through a two-flop synchronizer before any read path sees them. Reading the data register returns, bit by bit, either the stored register bit (for outputs) or the synchronized pin (for inputs). A separate read-only input register always returns the synchronized pins. Because of this, a pin that is driven one way but pulled the other way from outside shows up as a mismatch between the two registers.

Top module: `gpio_altmux_port`

## Requirements
- R1: After reset the data and direction registers hold 0, every output enable is low, and the data register reads back the synchronized pins.
- R2: On a pin with no alternate function enabled, the output enable equals its direction bit and the output value equals its data bit.
- R3: Reading address 0 (data) returns, per bit, the data bit where the direction bit is 1 and the synchronized pin where it is 0. Address 1 (direction) reads back the direction register.
- R4: Reading address 2 (input register) returns the synchronized pins, whatever the direction or alternate-function settings are. A pin change is visible after the second rising clock edge that follows it, not after the first.
- R5: A write to address 2 changes neither the data register, nor the direction register, nor what address 2 reads back.
- R6: With the serial function off, PWM enable bit 1 makes pin 1 an output carrying PWM value bit 1, and PWM enable bit 0 does the same for pin 0. A disabled PWM bit returns its pin to GPIO control.
- R7: With the serial function on, pin 1 is an output carrying the transmit value and pin 0 has its output enable low, regardless of the PWM and GPIO settings.
- R8: The serial receive output equals the synchronized value of pin 0.
- R9: If a GPIO output pin is driven high while an external source holds it low, the input register shows 0 on that bit and the data register still reads 1.
- R10: Address 3 reads as 0, and writes to it have no effect on the data or direction registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register address: 0 data, 1 direction, 2 input, 3 unused |
| regWrEn | input | 1 | Write strobe, taken at the rising edge |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| serEn | input | 1 | Serial function enable (pins 0 and 1) |
| serTxVal | input | 1 | Serial transmit value for pin 1 |
| serRxVal | output | 1 | Synchronized pin 0 for the serial receiver |
| pwmEn | input | 2 | PWM enables; bit 1 for pin 1, bit 0 for pin 0 |
| pwmVal | input | 2 | PWM values; bit 1 for pin 1, bit 0 for pin 0 |
| pinIn | input | 8 | Pad input levels |
| pinOut | output | 8 | Pad output values |
| pinOe | output | 8 | Pad output enables |

## Verification
Two functions can act in the same cycle. One is the owner of a shared pin changing, through the serial or PWM enables. The other is the GPIO view of that same pin, meaning the stored data and direction bits and the data-register readback. The bench sets the GPIO registers to drive pins 0 and 1 and then enables PWM and serial over them. It judges the pad outputs against the priority order, and it judges the register readback against the stored GPIO bits, which stay unchanged. A separate scenario holds a driven-high pin low from outside. It checks that, once two edges have passed, the input register and the data register disagree on that bit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W     = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_INPUT = 2'd2;

  // Write strobes from control to datapath
  typedef struct packed {
    logic wrData;
    logic wrDir;
  } regStrobe_t;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_INPUT = 2'd2,
    SEL_NONE  = 2'd3
  } rdSel_t;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] pinRaw,
  output logic [WIDTH-1:0] pinSync
);
  // No reset: the register tracks the pads from power-up
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) stage[0] <= pinRaw;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) stage[s] <= stage[s-1];
  end

  assign pinSync = stage[STAGES-1];
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobe,
  output rdSel_t            rdSel
);
  always_comb begin
    strobe = '0;
    rdSel  = SEL_NONE;
    unique case (regAddr)
      ADDR_DATA:  begin rdSel = SEL_DATA;  strobe.wrData = regWrEn; end
      ADDR_DIR:   begin rdSel = SEL_DIR;   strobe.wrDir  = regWrEn; end
      ADDR_INPUT: rdSel = SEL_INPUT;   // read-only, writes dropped
      default:    rdSel = SEL_NONE;
    endcase
  end

  // R5 / R10: at most one register strobed per cycle
  always_comb p_single_strobe_r5: assert ($onehot0({strobe.wrData, strobe.wrDir}));
endmodule

// File: rtl/gpio_port_dpath.sv
module gpio_port_dpath
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  rdSel_t           rdSel,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic             serEn,
  input  logic             serTxVal,
  output logic             serRxVal,
  input  logic [1:0]       pwmEn,
  input  logic [1:0]       pwmVal,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);
  localparam int unsigned RX_BIT = 0;
  localparam int unsigned TX_BIT = 1;

  logic [WIDTH-1:0] dataReg, dirReg, pinSync, dataView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
    end else begin
      if (strobe.wrData) dataReg <= wrData;
      if (strobe.wrDir)  dirReg  <= wrData;
    end
  end

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .pinRaw(pinIn), .pinSync(pinSync)
  );

  assign serRxVal = pinSync[RX_BIT];
  assign dataView = (dataReg & dirReg) | (pinSync & ~dirReg);

  always_comb begin
    unique case (rdSel)
      SEL_DATA:  rdData = dataView;
      SEL_DIR:   rdData = dirReg;
      SEL_INPUT: rdData = pinSync;
      default:   rdData = '0;
    endcase
  end

  // Per-pin ownership: serial > PWM > GPIO on shared pins
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i == RX_BIT || i == TX_BIT) begin : g_shared
      always_comb begin
        if (serEn) begin
          pinOe[i]  = (i == TX_BIT);
          pinOut[i] = (i == TX_BIT) ? serTxVal : 1'b0;
        end else if (pwmEn[i]) begin
          pinOe[i]  = 1'b1;
          pinOut[i] = pwmVal[i];
        end else begin
          pinOe[i]  = dirReg[i];
          pinOut[i] = dataReg[i];
        end
      end
    end else begin : g_plain
      assign pinOe[i]  = dirReg[i];
      assign pinOut[i] = dataReg[i];
    end
  end

  // R5 / R10: registers change only under their own strobe
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrData |=> $stable(dataReg));
  p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrDir |=> $stable(dirReg));
  // R3: direction write lands next cycle
  p_dir_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDir |=> dirReg == $past(wrData));
  // R4: two-edge synchronizer latency
  if (SYNC_STAGES == 2) begin : g_lat_chk
    p_sync_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> pinSync == $past(pinIn, 2));
  end
endmodule

// File: rtl/gpio_altmux_port.sv
module gpio_altmux_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WIDTH-1:0]  regWrData,
  output logic [WIDTH-1:0]  regRdData,
  input  logic              serEn,
  input  logic              serTxVal,
  output logic              serRxVal,
  input  logic [1:0]        pwmEn,
  input  logic [1:0]        pwmVal,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe
);
  regStrobe_t strobe;
  rdSel_t     rdSel;

  gpio_port_ctrl u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .strobe(strobe), .rdSel(rdSel)
  );

  gpio_port_dpath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel),
    .wrData(regWrData), .rdData(regRdData),
    .serEn(serEn), .serTxVal(serTxVal), .serRxVal(serRxVal),
    .pwmEn(pwmEn), .pwmVal(pwmVal),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  // R7: serial owns both shared pins
  p_serial_owns_r7: assert property (@(posedge clk) disable iff (!rstN)
    serEn |-> (pinOe[1] && !pinOe[0] && pinOut[1] == serTxVal));
  // R6: PWM beats GPIO when serial is off
  p_pwm_owns_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!serEn && pwmEn[1]) |-> (pinOe[1] && pinOut[1] == pwmVal[1]));
  // R10: unused address reads zero
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd3) |-> (regRdData == '0));
endmodule

// File: tb/gpio_altmux_port_tb_top.sv
`timescale 1ns/1ps
module gpio_altmux_port_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       serEn = 1'b0, serTxVal = 1'b0, serRxVal;
  logic [1:0] pwmEn = '0, pwmVal = '0;
  logic [7:0] pinIn, pinOut, pinOe;
  logic [7:0] pullVal = 8'hA5, extForce = '0, extVal = '0;

  int nChecks = 0, nFails = 0;

  always #10 clk = ~clk;  // 50 MHz

  // Pad model: external force wins, then the port's driver, then the pull
  assign pinIn = (extForce & extVal) | (~extForce & ((pinOe & pinOut) | (~pinOe & pullVal)));

  gpio_altmux_port dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .serEn(serEn),
    .serTxVal(serTxVal), .serRxVal(serRxVal), .pwmEn(pwmEn), .pwmVal(pwmVal),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #2 d = regRdData;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 oe after reset", pinOe, 8'h00);
    rdReg(2'd1, v); check("R1 dir after reset", v, 8'h00);
    rdReg(2'd0, v); check("R1 data reads pins", v, 8'hA5);
  endtask

  task automatic t_gpio_out();
    logic [7:0] v;
    wrReg(2'd1, 8'hFF); wrReg(2'd0, 8'h3C); settle();
    check("R2 oe", pinOe, 8'hFF);
    check("R2 out", pinOut, 8'h3C);
    rdReg(2'd0, v); check("R3 data output readback", v, 8'h3C);
    rdReg(2'd2, v); check("R4 input reg sees driven pins", v, 8'h3C);
  endtask

  task automatic t_mixed_dir();
    logic [7:0] v;
    wrReg(2'd1, 8'h0F); wrReg(2'd0, 8'hFF); settle();
    rdReg(2'd0, v); check("R3 mixed direction", v, 8'hAF);
    rdReg(2'd1, v); check("R3 dir readback", v, 8'h0F);
  endtask

  task automatic t_latency();
    logic [7:0] v;
    wrReg(2'd1, 8'h00); settle();
    @(negedge clk); pullVal = 8'h5A; regAddr = 2'd2;
    @(negedge clk); #2 check("R4 not yet after one edge", regRdData, 8'hA5);
    @(negedge clk); #2 check("R4 visible after two edges", regRdData, 8'h5A);
    rdReg(2'd0, v); check("R3 input-mode data reads pins", v, 8'h5A);
  endtask

  task automatic t_input_wr();
    logic [7:0] v;
    wrReg(2'd1, 8'hF0); wrReg(2'd0, 8'h90);
    wrReg(2'd2, 8'h00);
    rdReg(2'd1, v); check("R5 dir after input write", v, 8'hF0);
    rdReg(2'd0, v); check("R5 data after input write", v, 8'h9A);
    rdReg(2'd2, v); check("R5 input reg unchanged", v, 8'h9A);
    wrReg(2'd3, 8'h00);
    rdReg(2'd3, v); check("R10 unused reads zero", v, 8'h00);
    rdReg(2'd1, v); check("R10 dir after unused write", v, 8'hF0);
    rdReg(2'd0, v); check("R10 data after unused write", v, 8'h9A);
  endtask

  task automatic t_pwm();
    logic [7:0] v;
    wrReg(2'd1, 8'h03); wrReg(2'd0, 8'h01); settle();
    @(negedge clk); pwmEn = 2'b11; pwmVal = 2'b10; #2;
    check("R6 pwm oe", {6'd0, pinOe[1:0]}, 8'h03);
    check("R6 pwm out", {6'd0, pinOut[1:0]}, 8'h02);
    rdReg(2'd0, v); check("R6 gpio data kept under pwm", v & 8'h03, 8'h01);
    @(negedge clk); pwmEn = 2'b01; #2;
    check("R6 pin1 back to gpio", {7'd0, pinOut[1]}, 8'h00);
    check("R6 pin0 still pwm", {7'd0, pinOut[0]}, 8'h00);
  endtask

  task automatic t_serial();
    logic [7:0] v;
    @(negedge clk); pwmEn = 2'b11; pwmVal = 2'b00; serEn = 1'b1; serTxVal = 1'b1; #2;
    check("R7 tx driven", {6'd0, pinOe[1:0]}, 8'h02);
    check("R7 tx value", {7'd0, pinOut[1]}, 8'h01);
    @(negedge clk); serTxVal = 1'b0; #2;
    check("R7 tx follows", {7'd0, pinOut[1]}, 8'h00);
    rdReg(2'd1, v); check("R7 dir kept under serial", v, 8'h03);
    @(negedge clk); extForce = 8'h01; extVal = 8'h00;
    settle(); check("R8 rx low", {7'd0, serRxVal}, 8'h00);
    @(negedge clk); extVal = 8'h01;
    settle(); check("R8 rx high", {7'd0, serRxVal}, 8'h01);
    @(negedge clk); serEn = 1'b0; pwmEn = 2'b00; extForce = 8'h00;
  endtask

  task automatic t_conflict();
    logic [7:0] v;
    wrReg(2'd1, 8'h10); wrReg(2'd0, 8'h10);
    @(negedge clk); extForce = 8'h10; extVal = 8'h00;
    settle();
    check("R9 pin drives high", {7'd0, pinOut[4]}, 8'h01);
    rdReg(2'd2, v); check("R9 input reg sees short", v & 8'h10, 8'h00);
    rdReg(2'd0, v); check("R9 data still reads 1", v & 8'h10, 8'h10);
    @(negedge clk); extForce = 8'h00;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    settle();
    t_reset();
    t_gpio_out();
    t_mixed_dir();
    t_latency();
    t_input_wr();
    t_pwm();
    t_serial();
    t_conflict();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule